// File: doc/BRIEF.md
# Dual-clock BCD up/down counter

This block keeps one decimal digit, a value from 0 to 9, and moves it up or down by one on the rising edges of two separate count inputs, one for each direction. A level-sensitive, active-low load copies a 4-bit value straight into the digit. An active-high clear forces the digit to zero. Two active-low terminal flags, a carry and a borrow, report when the digit sits at its end of the range while the matching count input is low.

The block runs on a free-running system clock. The two count inputs and the load input are treated as asynchronous. They are brought into the clock domain through a short synchronizer, and the rising edges of the two count inputs are found from the synchronized samples. Because each flag is gated by the low phase of its own count input, the carry of one digit can drive the count-up input of the next digit and the borrow can drive its count-down input. A chain of these blocks then forms a multi-digit decimal counter. A count input that is not in use is held high.

Top module: `decade_updown_ctr`

## Requirements
- R1: A rising edge on `upClk` adds one to `count`. From 9 the count goes to 0.
- R2: A rising edge on `downClk` subtracts one from `count`. From 0 the count goes to 9.
- R3: While `rst` is high, `count` is 0. It clears at once, with no clock edge needed, and this overrides a load that is active at the same time.
- R4: While the synchronized `loadN` is low, `count` takes the value of `loadData` on every clock edge. Edges on either count input are then ignored.
- R5: `carryN` is low only when `count` is 9 and the synchronized `upClk` is low. It goes back high when `upClk` rises.
- R6: `borrowN` is low only when `count` is 0 and the synchronized `downClk` is low. For any other count it stays high.
- R7: After `upClk`, `downClk` or `loadN` changes, `count` responds on the third rising edge of `clk`. `carryN` and `borrowN` follow the level of their count input after the second rising edge.
- R8: If rising edges of `upClk` and `downClk` are detected in the same clock cycle, `count` does not change.
- R9: A loaded value from 10 to 15 is held as given. From such a value a count up gives 0 and a count down gives 9.
- R10: When `carryN` of one block drives `upClk` of a second block and `borrowN` drives its `downClk`, the pair counts as two decimal digits, including the carry from 9 up and the borrow from 0 down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Asynchronous master clear, active high |
| upClk | input | 1 | Count-up input; counts on a rising edge and idles high |
| downClk | input | 1 | Count-down input; counts on a rising edge and idles high |
| loadN | input | 1 | Parallel load, active low, level sensitive |
| loadData | input | 4 | Value copied into the count during a load |
| count | output | 4 | Present BCD digit |
| carryN | output | 1 | Active-low terminal-count-up flag |
| borrowN | output | 1 | Active-low terminal-count-down flag |

## Verification
Each count input passes through two synchronizer flops and one edge-detect flop. A count therefore appears after the third clock edge following the input change, while the carry and borrow flags follow their input level after the second edge. The driver changes inputs one nanosecond after a rising edge and waits a known number of edges before it queues an expected value. The monitor compares at the next falling edge. The latency test queues one item after two edges, which must still show the old count, and one after the third edge, which must show the new count. Load follows a data change one edge later, because the data path is not synchronized. The asynchronous clear is checked half a cycle after `rst` rises, before any clock edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Strobes handed from the control to the datapath, one per clock cycle
  typedef struct packed {
    logic load;     // synchronized load is active
    logic incr;     // rising edge seen on the up input
    logic decr;     // rising edge seen on the down input
    logic upLow;    // synchronized up input is low
    logic downLow;  // synchronized down input is low
  } ctrStrobe_t;

endpackage

// File: rtl/ctr_sync.sv
module ctr_sync #(
  parameter int unsigned WIDTH     = 3,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ctr_control.sv
module ctr_control
  import ctr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       upClk,
  input  logic       downClk,
  input  logic       loadN,
  output ctrStrobe_t stb
);

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned UP_IDX = 0;
  localparam int unsigned DN_IDX = 1;
  localparam int unsigned LD_IDX = 2;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic              upPrev;
  logic              downPrev;

  assign rawIn[UP_IDX] = upClk;
  assign rawIn[DN_IDX] = downClk;
  assign rawIn[LD_IDX] = loadN;

  // All three inputs idle high, so the chain resets high to avoid a false edge
  ctr_sync #(
    .WIDTH    (NUM_IN),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({NUM_IN{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(syncIn)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      upPrev   <= 1'b1;
      downPrev <= 1'b1;
    end else begin
      upPrev   <= syncIn[UP_IDX];
      downPrev <= syncIn[DN_IDX];
    end
  end

  always_comb begin
    stb.load    = ~syncIn[LD_IDX];
    stb.incr    = syncIn[UP_IDX] & ~upPrev;
    stb.decr    = syncIn[DN_IDX] & ~downPrev;
    stb.upLow   = ~syncIn[UP_IDX];
    stb.downLow = ~syncIn[DN_IDX];
  end

endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned MAX_VALUE = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrStrobe_t       stb,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);

  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MAX_VALUE);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;
  logic [WIDTH-1:0] upValue;
  logic [WIDTH-1:0] downValue;
  logic             atTop;
  logic             atZero;

  assign atTop  = (countQ == TOP_VAL);
  assign atZero = (countQ == '0);

  // Values above the top of range step to the wrap targets in both directions
  assign upValue   = (countQ >= TOP_VAL) ? '0 : countQ + ONE;
  assign downValue = (atZero || countQ > TOP_VAL) ? TOP_VAL : countQ - ONE;

  always_comb begin
    countNext = countQ;
    if (stb.load) begin
      countNext = loadData;
    end else if (stb.incr && !stb.decr) begin
      countNext = upValue;
    end else if (stb.decr && !stb.incr) begin
      countNext = downValue;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) countQ <= '0;
    else     countQ <= countNext;
  end

  assign count   = countQ;
  assign carryN  = ~(atTop & stb.upLow);
  assign borrowN = ~(atZero & stb.downLow);

endmodule

// File: rtl/decade_updown_ctr.sv
module decade_updown_ctr
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned MAX_VALUE   = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upClk,
  input  logic             downClk,
  input  logic             loadN,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);

  ctrStrobe_t stb;

  ctr_control #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_control (
    .clk    (clk),
    .rst    (rst),
    .upClk  (upClk),
    .downClk(downClk),
    .loadN  (loadN),
    .stb    (stb)
  );

  ctr_datapath #(
    .WIDTH    (WIDTH),
    .MAX_VALUE(MAX_VALUE)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .loadData(loadData),
    .count   (count),
    .carryN  (carryN),
    .borrowN (borrowN)
  );

endmodule

// File: rtl/decade_updown_ctr_chk.sv
module decade_updown_ctr_chk
  import ctr_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned MAX_VALUE = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] loadData,
  input logic             carryN,
  input logic             borrowN,
  input ctrStrobe_t       stb
);

  localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(MAX_VALUE);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

  // R3: clear holds the count at zero whenever it is sampled high
  always @(posedge clk) begin
    if (rst) begin
      p_reset_clear_r3: assert (count == '0)
        else $error("count not cleared during reset");
    end
  end

  p_count_up_r1: assert property (@(posedge clk) disable iff (rst)
    stb.incr && !stb.decr && !stb.load |=>
      count == (($past(count) >= TOP_VAL) ? '0 : $past(count) + ONE));

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    stb.decr && !stb.incr && !stb.load |=>
      count == (($past(count) == '0 || $past(count) > TOP_VAL) ? TOP_VAL : $past(count) - ONE));

  p_load_copy_r4: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> count == $past(loadData));

  p_carry_at_top_r5: assert property (@(posedge clk) disable iff (rst)
    !carryN |-> count == TOP_VAL);

  p_borrow_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !borrowN |-> count == '0);

  p_both_edges_hold_r8: assert property (@(posedge clk) disable iff (rst)
    stb.incr && stb.decr && !stb.load |=> $stable(count));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stb.incr && !stb.decr && !stb.load |=> $stable(count));

endmodule

bind decade_updown_ctr decade_updown_ctr_chk #(
  .WIDTH    (WIDTH),
  .MAX_VALUE(MAX_VALUE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .count   (count),
  .loadData(loadData),
  .carryN  (carryN),
  .borrowN (borrowN),
  .stb     (stb)
);

// File: tb/test_decade_updown_ctr.sv
module test_decade_updown_ctr;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upClk = 1'b1;
  logic       downClk = 1'b1;
  logic       loadN = 1'b1;
  logic [3:0] loadData = 4'd0;
  logic [3:0] count;
  logic       carryN;
  logic       borrowN;

  // cascade pair
  logic       cUp = 1'b1;
  logic       cDown = 1'b1;
  logic [3:0] loCount;
  logic [3:0] hiCount;
  logic       loCarryN;
  logic       loBorrowN;
  logic       hiCarryN;
  logic       hiBorrowN;

  int testsRun = 0;
  int testsFailed = 0;
  int mCount = 0;

  typedef struct {
    int         which;
    logic [7:0] val;
    logic       cN;
    logic       bN;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #2 clk = ~clk;

  decade_updown_ctr i_decade_updown_ctr (
    .clk(clk), .rst(rst), .upClk(upClk), .downClk(downClk), .loadN(loadN),
    .loadData(loadData), .count(count), .carryN(carryN), .borrowN(borrowN)
  );

  decade_updown_ctr i_decade_updown_ctr_lo (
    .clk(clk), .rst(rst), .upClk(cUp), .downClk(cDown), .loadN(1'b1),
    .loadData(4'd0), .count(loCount), .carryN(loCarryN), .borrowN(loBorrowN)
  );

  decade_updown_ctr i_decade_updown_ctr_hi (
    .clk(clk), .rst(rst), .upClk(loCarryN), .downClk(loBorrowN), .loadN(1'b1),
    .loadData(4'd0), .count(hiCount), .carryN(hiCarryN), .borrowN(hiBorrowN)
  );

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Queue the expected outputs of the main counter from the bench model
  task automatic expectMain(input string tag);
    item_t it;
    it.which = 0;
    it.val   = 8'(mCount);
    it.cN    = !(mCount == 9 && upClk == 1'b0);
    it.bN    = !(mCount == 0 && downClk == 1'b0);
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic expectCascade(input logic [7:0] v, input string tag);
    item_t it;
    it.which = 1;
    it.val   = v;
    it.cN    = 1'b1;
    it.bN    = 1'b1;
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic pulseUp(input bit move);
    upClk = 1'b0;
    waitEdges(3);
    upClk = 1'b1;
    waitEdges(8);
    if (move) mCount = (mCount >= 9) ? 0 : mCount + 1;
  endtask

  task automatic pulseDown(input bit move);
    downClk = 1'b0;
    waitEdges(3);
    downClk = 1'b1;
    waitEdges(8);
    if (move) mCount = (mCount == 0 || mCount > 9) ? 9 : mCount - 1;
  endtask

  task automatic cascadeUp();
    cUp = 1'b0;
    waitEdges(3);
    cUp = 1'b1;
    waitEdges(8);
  endtask

  task automatic cascadeDown();
    cDown = 1'b0;
    waitEdges(3);
    cDown = 1'b1;
    waitEdges(8);
  endtask

  // Monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      testsRun++;
      if (it.which == 0) begin
        if (count !== it.val[3:0] || carryN !== it.cN || borrowN !== it.bN) begin
          testsFailed++;
          $display("FAIL %s: count=%0d carryN=%0b borrowN=%0b expected count=%0d carryN=%0b borrowN=%0b",
                   it.tag, count, carryN, borrowN, it.val, it.cN, it.bN);
        end
      end else begin
        if ({hiCount, loCount} !== it.val) begin
          testsFailed++;
          $display("FAIL %s: digits=%h expected %h", it.tag, {hiCount, loCount}, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    waitEdges(3);
    mCount = 0;
    expectMain("R3 reset state");
    loadN = 1'b0;
    loadData = 4'd5;
    waitEdges(4);
    expectMain("R3 reset overrides load");
    loadN = 1'b1;
    waitEdges(3);
    rst = 1'b0;
    waitEdges(4);

    // R1 counting up
    pulseUp(1); expectMain("R1 up to 1");
    pulseUp(1); expectMain("R1 up to 2");
    pulseUp(1); expectMain("R1 up to 3");

    // R7 latency: old value after two edges, new value after the third
    upClk = 1'b0;
    waitEdges(4);
    upClk = 1'b1;
    waitEdges(2);
    expectMain("R7 count unchanged after two edges");
    waitEdges(1);
    mCount = 4;
    expectMain("R7 count updated on third edge");
    waitEdges(4);

    // R4 load
    loadN = 1'b0;
    loadData = 4'd8;
    waitEdges(4);
    mCount = 8;
    expectMain("R4 load value");
    loadData = 4'd2;
    waitEdges(1);
    mCount = 2;
    expectMain("R4 load follows data");
    pulseUp(0);
    expectMain("R4 load beats up edge");
    pulseDown(0);
    expectMain("R4 load beats down edge");
    loadData = 4'd9;
    waitEdges(1);
    mCount = 9;
    loadN = 1'b1;
    waitEdges(4);
    expectMain("R4 value kept after load release");

    // R5 carry
    upClk = 1'b0;
    waitEdges(3);
    expectMain("R5 carry low at 9 with up low");
    upClk = 1'b1;
    waitEdges(2);
    expectMain("R5 carry high again on up rise");
    waitEdges(4);
    mCount = 0;
    expectMain("R1 wrap 9 to 0");

    // R6 borrow
    downClk = 1'b0;
    waitEdges(3);
    expectMain("R6 borrow low at 0 with down low");
    downClk = 1'b1;
    waitEdges(4);
    mCount = 9;
    expectMain("R2 wrap 0 to 9");
    pulseDown(1);
    pulseDown(1);
    expectMain("R2 down to 7");
    downClk = 1'b0;
    waitEdges(3);
    expectMain("R6 borrow high at nonzero count");
    downClk = 1'b1;
    waitEdges(4);
    mCount = 6;
    expectMain("R2 down to 6");

    // R8 simultaneous edges
    upClk = 1'b0;
    downClk = 1'b0;
    waitEdges(4);
    upClk = 1'b1;
    downClk = 1'b1;
    waitEdges(5);
    expectMain("R8 both edges leave count");

    // R9 out-of-range values
    loadN = 1'b0;
    loadData = 4'd12;
    waitEdges(4);
    loadN = 1'b1;
    waitEdges(4);
    mCount = 12;
    expectMain("R9 value 12 held");
    pulseUp(1);
    expectMain("R9 up from 12 gives 0");
    loadN = 1'b0;
    loadData = 4'd14;
    waitEdges(4);
    loadN = 1'b1;
    waitEdges(4);
    mCount = 14;
    pulseDown(1);
    expectMain("R9 down from 14 gives 9");

    // R3 asynchronous clear mid-run
    pulseDown(1);
    expectMain("R2 down to 8");
    @(posedge clk);
    #0.5;
    rst = 1'b1;
    #0.5;
    mCount = 0;
    expectMain("R3 async clear before edge");
    waitEdges(3);
    rst = 1'b0;
    waitEdges(4);

    // R10 cascade
    for (int i = 0; i < 12; i++) cascadeUp();
    expectCascade(8'h12, "R10 cascade up to 12");
    for (int i = 0; i < 3; i++) cascadeDown();
    expectCascade(8'h09, "R10 cascade borrow to 09");

    waitEdges(2);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule